// File: doc/BRIEF.md
# Shadow-Stack Enable and Pointer-Access Gate

This block decides, for the privilege mode a hart is running in, whether shadow stacks are active in that mode. It also decides what happens when software tries to touch the shadow-stack-pointer CSR. The inputs are the current mode and the shadow-stack enable bits of the machine, hypervisor and supervisor environment-configuration registers. The outputs are a per-mode enable and a two-bit verdict: allow, raise an illegal-instruction exception, or raise a virtual-instruction exception.

The CSR unit pulses `req_i` while it presents the mode and the three enable bits. One clock edge later the block shows the verdict and the enable, together with a one-cycle `valid_o` pulse. Both stay unchanged until the next request. The parameter `HAS_SMODE` selects a hart with or without supervisor mode. A hart without supervisor mode has no supervisor or hypervisor configuration registers.

Top module: `ss_access_check`

## Requirements
- R1: In machine mode (`mode_i` = 3'b011) the enable is 0 and the verdict is allow (2'b00), whatever the enable bits are.
- R2: With `HAS_SMODE`=1 the enable comes from one bit selected by the mode. In supervisor mode (3'b001) it is `menv_sse_i`. In virtual supervisor mode (3'b101) it is `henv_sse_i`. In user mode (3'b000) and virtual user mode (3'b100) it is `senv_sse_i`.
- R3: With `HAS_SMODE`=0 the enable is 0 in every mode, and `henv_sse_i` and `senv_sse_i` have no effect. Every mode other than machine mode gets the verdict illegal (2'b01).
- R4: In any mode below machine mode, `menv_sse_i`=0 gives illegal (2'b01). This takes priority over every other check, including in the virtual modes.
- R5: If R4 does not apply, user mode with `senv_sse_i`=0 gives illegal (2'b01).
- R6: If R4 does not apply, virtual supervisor mode with `henv_sse_i`=0 gives virtual-instruction (2'b10).
- R7: If R4 does not apply, virtual user mode with `henv_sse_i`=0 or `senv_sse_i`=0 gives virtual-instruction (2'b10).
- R8: Any access not caught by R4 to R7 gets allow (2'b00). The verdict is never 2'b11.
- R9: The verdict and enable for a request appear on the clock edge after `req_i` is sampled high. `valid_o` is high for exactly that one cycle.
- R10: While `req_i` is low, changes on `mode_i` and the enable bits leave `verdict_o` and `sse_o` unchanged, and `valid_o` stays low.
- R11: The reserved mode encodings 3'b010, 3'b110 and 3'b111 give enable 0 and verdict illegal (2'b01).
- R12: While `rst_ni` is low, `valid_o`, `sse_o` and `verdict_o` are all 0. This takes effect at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe: evaluate this cycle's inputs |
| mode_i | input | 3 | Privilege mode: bit 2 = virtualized, bits 1:0 = privilege level |
| menv_sse_i | input | 1 | Machine environment-configuration shadow-stack enable |
| henv_sse_i | input | 1 | Hypervisor environment-configuration shadow-stack enable |
| senv_sse_i | input | 1 | Supervisor environment-configuration shadow-stack enable |
| valid_o | output | 1 | One-cycle pulse: the result is new |
| sse_o | output | 1 | Shadow-stack enable in the requested mode |
| verdict_o | output | 2 | 00 allow, 01 illegal-instruction, 10 virtual-instruction |

## Verification
The bench builds two copies of the block side by side, one with `HAS_SMODE`=1 and one with `HAS_SMODE`=0, and drives the same requests into both. The first copy brings the full ordered priority chain within reach: both virtual modes, where a missing machine enable must still produce illegal rather than virtual, and the split between the two exception kinds. The second copy shows that the supervisor and hypervisor enable bits have no effect and that every mode below machine mode is refused.

// File: rtl/ss_chk_pkg.sv
package ss_chk_pkg;

  localparam int unsigned MODE_W = 3;
  localparam int unsigned VERD_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_U    = 3'b000,
    MODE_S    = 3'b001,
    MODE_RSV2 = 3'b010,
    MODE_M    = 3'b011,
    MODE_VU   = 3'b100,
    MODE_VS   = 3'b101,
    MODE_RSV6 = 3'b110,
    MODE_RSV7 = 3'b111
  } priv_mode_e;

  typedef enum logic [VERD_W-1:0] {
    VERD_ALLOW   = 2'b00,
    VERD_ILLEGAL = 2'b01,
    VERD_VIRTUAL = 2'b10
  } verdict_e;

  typedef struct packed {
    logic menv;
    logic henv;
    logic senv;
  } sse_bits_t;

endpackage

// File: rtl/ss_enable_map.sv
module ss_enable_map
  import ss_chk_pkg::*;
#(
  parameter bit HAS_SMODE = 1'b1
) (
  input  priv_mode_e mode_i,
  input  sse_bits_t  bits_i,
  output logic       sse_o
);

  if (HAS_SMODE) begin : g_smode
    always_comb begin
      unique case (mode_i)
        MODE_S:          sse_o = bits_i.menv;
        MODE_VS:         sse_o = bits_i.henv;
        MODE_U, MODE_VU: sse_o = bits_i.senv;
        default:         sse_o = 1'b0;
      endcase
    end
  end else begin : g_no_smode
    // no S-mode: shadow stacks cannot be activated in M or U
    logic unused;
    assign unused = ^{mode_i, bits_i};
    assign sse_o  = 1'b0;
  end

endmodule

// File: rtl/ss_csr_gate.sv
module ss_csr_gate
  import ss_chk_pkg::*;
#(
  parameter bit HAS_SMODE = 1'b1
) (
  input  priv_mode_e mode_i,
  input  sse_bits_t  bits_i,
  output verdict_e   verdict_o
);

  logic is_rsv;
  assign is_rsv = (mode_i == MODE_RSV2) || (mode_i == MODE_RSV6) ||
                  (mode_i == MODE_RSV7);

  if (HAS_SMODE) begin : g_smode
    // ordered priority chain, first match wins
    always_comb begin
      if (mode_i == MODE_M)                          verdict_o = VERD_ALLOW;
      else if (is_rsv)                               verdict_o = VERD_ILLEGAL;
      else if (!bits_i.menv)                         verdict_o = VERD_ILLEGAL;
      else if (mode_i == MODE_U && !bits_i.senv)     verdict_o = VERD_ILLEGAL;
      else if (mode_i == MODE_VS && !bits_i.henv)    verdict_o = VERD_VIRTUAL;
      else if (mode_i == MODE_VU &&
               !(bits_i.henv && bits_i.senv))        verdict_o = VERD_VIRTUAL;
      else                                           verdict_o = VERD_ALLOW;
    end
  end else begin : g_no_smode
    // absent senvcfg reads as zero: every non-M access fails
    logic unused;
    assign unused    = ^{bits_i, is_rsv};
    assign verdict_o = (mode_i == MODE_M) ? VERD_ALLOW : VERD_ILLEGAL;
  end

endmodule

// File: rtl/ss_access_check.sv
module ss_access_check
  import ss_chk_pkg::*;
#(
  parameter bit HAS_SMODE = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic [MODE_W-1:0]       mode_i,
  input  logic                    menv_sse_i,
  input  logic                    henv_sse_i,
  input  logic                    senv_sse_i,
  output logic                    valid_o,
  output logic                    sse_o,
  output logic [VERD_W-1:0]       verdict_o
);

  priv_mode_e mode;
  sse_bits_t  bits;
  logic       sse_d;
  verdict_e   verd_d;

  assign mode = priv_mode_e'(mode_i);
  assign bits = '{menv: menv_sse_i, henv: henv_sse_i, senv: senv_sse_i};

  ss_enable_map #(.HAS_SMODE(HAS_SMODE)) i_enable_map (
    .mode_i (mode),
    .bits_i (bits),
    .sse_o  (sse_d)
  );

  ss_csr_gate #(.HAS_SMODE(HAS_SMODE)) i_csr_gate (
    .mode_i    (mode),
    .bits_i    (bits),
    .verdict_o (verd_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      sse_o     <= 1'b0;
      verdict_o <= VERD_ALLOW;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        sse_o     <= sse_d;
        verdict_o <= verd_d;
      end
    end
  end

  a_r1_m_mode_allow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && mode_i == MODE_M |=> !sse_o && verdict_o == VERD_ALLOW);

  a_r4_menv_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && mode_i != MODE_M && !menv_sse_i |=> verdict_o == VERD_ILLEGAL);

  a_r6_virt_only_virtual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !mode_i[2] |=> verdict_o != VERD_VIRTUAL);

  a_r8_no_bad_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_o != 2'b11);

  a_r9_valid_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);

  a_r9_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);

  a_r10_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(verdict_o) && $stable(sse_o));

  a_r3_no_smode_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !HAS_SMODE && req_i |=> !sse_o);

endmodule

// File: tb/test_ss_access_check.sv
module test_ss_access_check;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 24;

  // {mode[2:0], menv, henv, senv, exp_sse, exp_verdict[1:0]}
  localparam logic [8:0] VEC [NVEC] = '{
    {3'b011, 3'b111, 1'b0, 2'b00},  // R1 M all on
    {3'b011, 3'b000, 1'b0, 2'b00},  // R1 M all off
    {3'b001, 3'b100, 1'b1, 2'b00},  // R2 S on
    {3'b001, 3'b011, 1'b0, 2'b01},  // R4 S menv off
    {3'b000, 3'b101, 1'b1, 2'b00},  // R2 U on
    {3'b000, 3'b110, 1'b0, 2'b01},  // R5 U senv off
    {3'b000, 3'b001, 1'b1, 2'b01},  // R4 U menv off
    {3'b101, 3'b110, 1'b1, 2'b00},  // R2 VS on
    {3'b101, 3'b101, 1'b0, 2'b10},  // R6 VS henv off
    {3'b101, 3'b010, 1'b1, 2'b01},  // R4 VS menv off beats virtual
    {3'b100, 3'b111, 1'b1, 2'b00},  // R8 VU allowed
    {3'b100, 3'b101, 1'b1, 2'b10},  // R7 VU henv off
    {3'b100, 3'b110, 1'b0, 2'b10},  // R7 VU senv off
    {3'b100, 3'b100, 1'b0, 2'b10},  // R7 VU both off
    {3'b100, 3'b011, 1'b1, 2'b01},  // R4 VU menv off
    {3'b010, 3'b111, 1'b0, 2'b01},  // R11 reserved
    {3'b110, 3'b111, 1'b0, 2'b01},  // R11 reserved
    {3'b111, 3'b111, 1'b0, 2'b01},  // R11 reserved
    {3'b001, 3'b111, 1'b1, 2'b00},  // R8 S all on
    {3'b101, 3'b011, 1'b1, 2'b01},  // R4 VS
    {3'b000, 3'b111, 1'b1, 2'b00},  // R8 U all on
    {3'b000, 3'b000, 1'b0, 2'b01},  // R4 U all off
    {3'b101, 3'b111, 1'b1, 2'b00},  // R8 VS all on
    {3'b011, 3'b010, 1'b0, 2'b00}   // R1 M mixed
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [2:0] mode = 3'b000;
  logic       menv = 1'b0, henv = 1'b0, senv = 1'b0;
  logic       valid_a, sse_a, valid_b, sse_b;
  logic [1:0] verd_a, verd_b;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ss_access_check #(.HAS_SMODE(1'b1)) i_ss_access_check (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .mode_i(mode),
    .menv_sse_i(menv), .henv_sse_i(henv), .senv_sse_i(senv),
    .valid_o(valid_a), .sse_o(sse_a), .verdict_o(verd_a));

  ss_access_check #(.HAS_SMODE(1'b0)) i_ss_access_check_nos (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .mode_i(mode),
    .menv_sse_i(menv), .henv_sse_i(henv), .senv_sse_i(senv),
    .valid_o(valid_b), .sse_o(sse_b), .verdict_o(verd_b));

  task automatic check(string req_tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req_tag, what, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] m, logic [2:0] env);
    @(negedge clk);
    mode = m; {menv, henv, senv} = env; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R12", "reset valid", valid_a, 0);
    check("R12", "reset sse", sse_a, 0);
    check("R12", "reset verdict", verd_a, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      issue(VEC[i][8:6], VEC[i][5:3]);
      check("R9", "valid pulse", valid_a, 1);
      check("R2", $sformatf("vec %0d sse", i), sse_a, VEC[i][2]);
      check("R4", $sformatf("vec %0d verdict", i), verd_a, VEC[i][1:0]);
      // R3: no S-mode variant, same stimulus
      check("R3", $sformatf("vec %0d nos sse", i), sse_b, 0);
      check("R3", $sformatf("vec %0d nos verdict", i), verd_b,
            (VEC[i][8:6] == 3'b011) ? 0 : 1);
    end

    // R10: idle input changes do not move the result
    issue(3'b101, 3'b101);
    mode = 3'b100; {menv, henv, senv} = 3'b111;
    @(negedge clk);
    check("R10", "idle valid low", valid_a, 0);
    check("R10", "idle verdict hold", verd_a, 2);
    check("R10", "idle sse hold", sse_a, 0);
    mode = 3'b011;
    @(negedge clk);
    check("R10", "idle verdict hold 2", verd_a, 2);

    // R9: back-to-back requests each get their own result
    @(negedge clk);
    mode = 3'b001; {menv, henv, senv} = 3'b100; req = 1'b1;
    @(negedge clk);
    check("R9", "b2b first verdict", verd_a, 0);
    check("R9", "b2b first sse", sse_a, 1);
    mode = 3'b000; {menv, henv, senv} = 3'b100;
    @(negedge clk);
    req = 1'b0;
    check("R5", "b2b second verdict", verd_a, 1);
    check("R9", "b2b second valid", valid_a, 1);
    @(negedge clk);
    check("R9", "valid drops", valid_a, 0);

    // R12: asynchronous reset mid-run
    issue(3'b100, 3'b111);
    check("R7", "pre-reset sse", sse_a, 1);
    #1 rst_n = 1'b0;
    #1;
    check("R12", "async reset sse", sse_a, 0);
    check("R12", "async reset verdict", verd_a, 0);
    check("R12", "async reset valid", valid_a, 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule